// File: doc/BRIEF.md
# CPU Debug Control Register Unit

This block is a small debug slave placed next to a pipelined processor. An external debugger reaches it over a simple command/response bus. Through it the debugger can stop the processor, hold it in reset, watch whether it has stopped, and see the last value the processor wrote into its register file. The command side carries a write flag, a byte address and a data word, with valid/ready handshaking. Every accepted command gets one response word exactly one clock later.

All control goes through a single write word at the control address. Separate bits set and clear each flag. One clear bit drops both the debugger's halt request and the breakpoint-halt flag. The unit has its own reset, separate from the processor reset it drives, so that it stays alive while it holds the processor in reset.

Top module: `dbg_ctrl_unit`

## Requirements
- R1: Each accepted command (cmdValid high while cmdReady is high at a clock edge) raises rspValid for exactly the following cycle. rspValid is low in every other cycle. rspData is zero whenever rspValid is low and for every write response.
- R2: A write to address 0x00 with data bit 16 set makes the reset flag 1, and with data bit 24 set makes it 0. cpuResetReq equals the reset flag.
- R3: A write to address 0x00 with data bit 17 set makes the halt flag 1, which drives cpuHaltReq high.
- R4: A write to address 0x00 with data bit 25 set clears both the halt flag and the breakpoint flag in the same cycle.
- R5: When a single write both sets and clears a flag, the flag ends up cleared. This also applies to a breakpoint hit arriving in the same cycle as a bit-25 clear.
- R6: A cpuBreakHit pulse sets the breakpoint flag. cpuHaltReq stays high while the halt flag or the breakpoint flag is set.
- R7: A read of address 0x04 returns the rfWrData captured at the most recent cycle in which rfWrEn was high. Data presented while rfWrEn is low is not captured.
- R8: A read of address 0x00 returns the following bits, with all other bits zero:
  - bit 0: reset flag
  - bit 1: halt flag
  - bit 2: cpuHalted
  - bit 3: breakpoint flag
  - bit 4: step flag
- R9: Every write to address 0x00 loads the step flag from data bit 4.
- R10: Reads of any address other than 0x00 and 0x04 return zero. Writes to them change no flag.
- R11: After dbgRstN, all flags, the captured word and all outputs are zero except cmdReady. While cpuResetReq is high the unit keeps accepting and answering commands.
- R12: A read response reflects the state before any change made in the cycle the read is accepted. That covers register-file captures and breakpoint hits in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| dbgRstN | input | 1 | Active-low asynchronous reset of the debug unit only |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Unit can take a command |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAddr | input | ADDR_W (8) | Byte address of the register |
| cmdData | input | DATA_W (32) | Write data |
| rspValid | output | 1 | Response word valid, one cycle after acceptance |
| rspData | output | DATA_W (32) | Response word |
| cpuHalted | input | 1 | Processor reports that it has stopped |
| cpuBreakHit | input | 1 | Processor executed a breakpoint instruction (pulse) |
| rfWrEn | input | 1 | Qualified register-file write strobe |
| rfWrData | input | DATA_W (32) | Value being written to the register file |
| cpuHaltReq | output | 1 | Halt request to the processor |
| cpuResetReq | output | 1 | Reset request to the processor |

## Verification
The bench goes after the following corner cases, and says what a faulty design would show in each:
- **Set and clear in one word, for each flag.** A design that let the set win would leave the processor halted or held in reset after a clear.
- **A breakpoint hit in the same cycle as the combined clear.** A wrong priority would leave a stale breakpoint halt.
- **A read taken in the same cycle as a register-file write or a breakpoint hit.** A design that forwarded the new value would return data one event early.
- **Strobe-less register-file data, unknown addresses and back-to-back commands.** These catch capture without the enable, aliasing onto the control register, and responses that are dropped or stretched.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;

  // control-word bit positions (the debugger's software depends on them)
  localparam int unsigned BIT_STEP     = 4;
  localparam int unsigned BIT_SET_RST  = 16;
  localparam int unsigned BIT_SET_HALT = 17;
  localparam int unsigned BIT_CLR_RST  = 24;
  localparam int unsigned BIT_CLR_HALT = 25;

  // status-word bit positions
  localparam int unsigned ST_RST  = 0;
  localparam int unsigned ST_HALT = 1;
  localparam int unsigned ST_CPU  = 2;
  localparam int unsigned ST_BRK  = 3;
  localparam int unsigned ST_STEP = 4;

  // register addresses (byte)
  localparam int unsigned CTL_ADDR = 0;
  localparam int unsigned RF_ADDR  = 4;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_LASTRF = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   setRst;
    logic   clrRst;
    logic   setHalt;
    logic   clrHalt;
    logic   loadStep;
    logic   stepVal;
    logic   rspFire;
    rdSel_e rdSel;
  } dbgStrobes_t;

endpackage

// File: rtl/dbg_ctrl_dec.sv
module dbg_ctrl_dec
  import dbg_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              cmdReady,
  output dbgStrobes_t       strb
);

  localparam logic [ADDR_W-1:0] CtlAddr = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] RfAddr  = ADDR_W'(RF_ADDR);

  logic accept;
  logic hitCtl;
  logic hitRf;
  logic wrCtl;
  logic unused_cmd;

  // the unit never stalls a command
  assign cmdReady   = 1'b1;
  assign accept     = cmdValid && cmdReady;
  assign hitCtl     = (cmdAddr == CtlAddr);
  assign hitRf      = (cmdAddr == RfAddr);
  assign wrCtl      = accept && cmdWrite && hitCtl;
  assign unused_cmd = ^cmdData;

  always_comb begin
    strb          = '0;
    strb.rspFire  = accept;
    strb.setRst   = wrCtl && cmdData[BIT_SET_RST];
    strb.clrRst   = wrCtl && cmdData[BIT_CLR_RST];
    strb.setHalt  = wrCtl && cmdData[BIT_SET_HALT];
    strb.clrHalt  = wrCtl && cmdData[BIT_CLR_HALT];
    strb.loadStep = wrCtl;
    strb.stepVal  = cmdData[BIT_STEP];
    strb.rdSel    = SEL_NONE;
    if (accept && !cmdWrite) begin
      if (hitCtl)     strb.rdSel = SEL_STATUS;
      else if (hitRf) strb.rdSel = SEL_LASTRF;
    end
  end

endmodule

// File: rtl/dbg_ctrl_dp.sv
module dbg_ctrl_dp
  import dbg_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbgStrobes_t       strb,
  input  logic              cpuHalted,
  input  logic              cpuBreakHit,
  input  logic              rfWrEn,
  input  logic [DATA_W-1:0] rfWrData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              cpuHaltReq,
  output logic              cpuResetReq
);

  logic              resetIt;
  logic              haltIt;
  logic              haltedByBreak;
  logic              stepMode;
  logic [DATA_W-1:0] lastRf;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    statusWord          = '0;
    statusWord[ST_RST]  = resetIt;
    statusWord[ST_HALT] = haltIt;
    statusWord[ST_CPU]  = cpuHalted;
    statusWord[ST_BRK]  = haltedByBreak;
    statusWord[ST_STEP] = stepMode;
  end

  always_comb begin
    case (strb.rdSel)
      SEL_STATUS: rdMux = statusWord;
      SEL_LASTRF: rdMux = lastRf;
      default:    rdMux = '0;
    endcase
  end

  // flags: clear has priority over set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetIt       <= 1'b0;
      haltIt        <= 1'b0;
      haltedByBreak <= 1'b0;
      stepMode      <= 1'b0;
    end else begin
      resetIt       <= (resetIt | strb.setRst) & ~strb.clrRst;
      haltIt        <= (haltIt | strb.setHalt) & ~strb.clrHalt;
      haltedByBreak <= (haltedByBreak | cpuBreakHit) & ~strb.clrHalt;
      if (strb.loadStep) stepMode <= strb.stepVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       lastRf <= '0;
    else if (rfWrEn) lastRf <= rfWrData;
  end

  // response sampled from pre-update state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.rspFire;
      rspData  <= strb.rspFire ? rdMux : '0;
    end
  end

  assign cpuHaltReq  = haltIt | haltedByBreak;
  assign cpuResetReq = resetIt;

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.rspFire |=> rspValid);
  assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rspFire |=> (!rspValid && rspData == '0));
  assert_rst_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setRst && !strb.clrRst) |=> cpuResetReq);
  assert_halt_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setHalt && !strb.clrHalt) |=> cpuHaltReq);
  assert_halt_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrHalt |=> !cpuHaltReq);
  assert_rst_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrRst |=> !cpuResetReq);
  assert_break_halts_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuBreakHit && !strb.clrHalt) |=> cpuHaltReq);
  assert_rf_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rfWrEn |=> $stable(lastRf));

endmodule

// File: rtl/dbg_ctrl_unit.sv
module dbg_ctrl_unit
  import dbg_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              dbgRstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  input  logic              cpuHalted,
  input  logic              cpuBreakHit,
  input  logic              rfWrEn,
  input  logic [DATA_W-1:0] rfWrData,
  output logic              cpuHaltReq,
  output logic              cpuResetReq
);

  dbgStrobes_t strb;

  dbg_ctrl_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .cmdValid (cmdValid),
    .cmdWrite (cmdWrite),
    .cmdAddr  (cmdAddr),
    .cmdData  (cmdData),
    .cmdReady (cmdReady),
    .strb     (strb)
  );

  dbg_ctrl_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (dbgRstN),
    .strb        (strb),
    .cpuHalted   (cpuHalted),
    .cpuBreakHit (cpuBreakHit),
    .rfWrEn      (rfWrEn),
    .rfWrData    (rfWrData),
    .rspValid    (rspValid),
    .rspData     (rspData),
    .cpuHaltReq  (cpuHaltReq),
    .cpuResetReq (cpuResetReq)
  );

endmodule

// File: tb/dbg_ctrl_unit_tb.sv
`timescale 1ns/1ps
module dbg_ctrl_unit_tb;

  logic        clk = 1'b0;
  logic        dbgRstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic        cmdWrite = 1'b0;
  logic [7:0]  cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        cpuHalted = 1'b0;
  logic        cpuBreakHit = 1'b0;
  logic        rfWrEn = 1'b0;
  logic [31:0] rfWrData = '0;
  logic        cpuHaltReq;
  logic        cpuResetReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dbg_ctrl_unit u_dut (
    .clk(clk), .dbgRstN(dbgRstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .rspValid(rspValid), .rspData(rspData), .cpuHalted(cpuHalted),
    .cpuBreakHit(cpuBreakHit), .rfWrEn(rfWrEn), .rfWrData(rfWrData),
    .cpuHaltReq(cpuHaltReq), .cpuResetReq(cpuResetReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit        mRst, mHalt, mBrk, mStep, mRspV;
  bit [31:0] mLast, mRspD;

  always @(posedge clk) begin
    bit [31:0] st;
    if (!dbgRstN) begin
      mRst = 0; mHalt = 0; mBrk = 0; mStep = 0; mRspV = 0; mRspD = 0; mLast = 0;
    end else begin
      st = {27'd0, mStep, mBrk, cpuHalted, mHalt, mRst};
      mRspV = cmdValid;
      mRspD = 0;
      if (cmdValid && !cmdWrite)
        mRspD = (cmdAddr == 8'h00) ? st : (cmdAddr == 8'h04) ? mLast : 32'd0;
      if (cmdValid && cmdWrite && cmdAddr == 8'h00) begin
        mRst  = (mRst  | cmdData[16]) & ~cmdData[24];
        mHalt = (mHalt | cmdData[17]) & ~cmdData[25];
        mBrk  = mBrk & ~cmdData[25];
        mStep = cmdData[4];
        if (cpuBreakHit && !cmdData[25]) mBrk = 1;
      end else if (cpuBreakHit) mBrk = 1;
      if (rfWrEn) mLast = rfWrData;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (dbgRstN && !done) begin
      check("R1 rspValid", 32'(rspValid), 32'(mRspV));
      check("R1 rspData", rspData, mRspD);
      check("R6 cpuHaltReq", 32'(cpuHaltReq), 32'(mHalt | mBrk));
      check("R2 cpuResetReq", 32'(cpuResetReq), 32'(mRst));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cmdValid = 1; cmdWrite = 1; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 0; cmdWrite = 0; cmdData = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cmdValid = 1; cmdWrite = 0; cmdAddr = a;
    @(negedge clk);
    d = rspValid ? rspData : 32'hDEAD_BEEF;
    cmdValid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    dbgRstN = 1;
    // R11 reset state
    check("R11 reset haltReq", 32'(cpuHaltReq), 0);
    check("R11 reset resetReq", 32'(cpuResetReq), 0);
    check("R11 reset rspValid", 32'(rspValid), 0);
    rd(8'h00, d); check("R11 status after reset", d, 32'h0);
    rd(8'h04, d); check("R11 lastRf after reset", d, 32'h0);

    // R2 reset flag
    wr(8'h00, 32'h0001_0000);
    check("R2 resetReq set", 32'(cpuResetReq), 1);
    rd(8'h00, d); check("R2 status reset bit", d, 32'h1);
    rd(8'h04, d); check("R11 unit alive under cpu reset", d, 32'h0);
    wr(8'h00, 32'h0100_0000);
    check("R2 resetReq cleared", 32'(cpuResetReq), 0);

    // R3 halt flag, R8 layout with cpuHalted
    wr(8'h00, 32'h0002_0000);
    check("R3 haltReq set", 32'(cpuHaltReq), 1);
    cpuHalted = 1;
    rd(8'h00, d); check("R8 status halt+cpuHalted", d, 32'h6);

    // R4 combined clear
    wr(8'h00, 32'h0200_0000);
    check("R4 haltReq cleared", 32'(cpuHaltReq), 0);
    rd(8'h00, d); check("R4 status after clear", d, 32'h4);

    // R6 breakpoint
    @(negedge clk); cpuBreakHit = 1;
    @(negedge clk); cpuBreakHit = 0;
    check("R6 haltReq from break", 32'(cpuHaltReq), 1);
    rd(8'h00, d); check("R6 status break bit", d, 32'hC);

    // R5 set+clear together while break set
    wr(8'h00, 32'h0202_0000);
    check("R5 halt set+clear", 32'(cpuHaltReq), 0);
    rd(8'h00, d); check("R4 break cleared by bit25", d, 32'h4);
    wr(8'h00, 32'h0101_0000);
    check("R5 reset set+clear", 32'(cpuResetReq), 0);

    // R5 break hit vs clear same cycle
    @(negedge clk);
    cpuBreakHit = 1; cmdValid = 1; cmdWrite = 1; cmdAddr = 8'h00; cmdData = 32'h0200_0000;
    @(negedge clk);
    cpuBreakHit = 0; cmdValid = 0; cmdWrite = 0; cmdData = 0;
    check("R5 break vs clear", 32'(cpuHaltReq), 0);

    // R9 step flag
    wr(8'h00, 32'h0000_0010);
    rd(8'h00, d); check("R9 step set", d, 32'h14);
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, d); check("R9 step reloaded zero", d, 32'h4);
    cpuHalted = 0;

    // R7 capture
    @(negedge clk); rfWrEn = 1; rfWrData = 32'hA5A5_0001;
    @(negedge clk); rfWrEn = 0; rfWrData = 32'h1234_5678;
    rd(8'h04, d); check("R7 captured value", d, 32'hA5A5_0001);
    rd(8'h04, d); check("R7 unqualified data ignored", d, 32'hA5A5_0001);

    // R12 read concurrent with capture and break
    @(negedge clk);
    cmdValid = 1; cmdWrite = 0; cmdAddr = 8'h04; rfWrEn = 1; rfWrData = 32'hCAFE_0002;
    @(negedge clk);
    check("R12 read sees old rf", rspData, 32'hA5A5_0001);
    cmdAddr = 8'h00; rfWrEn = 0; cpuBreakHit = 1;
    @(negedge clk);
    check("R12 read sees pre-break status", rspData, 32'h0);
    cmdValid = 0; cpuBreakHit = 0;
    rd(8'h04, d); check("R7 new capture", d, 32'hCAFE_0002);
    wr(8'h00, 32'h0200_0000);

    // R10 other addresses
    wr(8'h08, 32'h0303_0010);
    rd(8'h00, d); check("R10 foreign write ignored", d, 32'h0);
    rd(8'h08, d); check("R10 foreign read zero", d, 32'h0);
    rd(8'hFC, d); check("R10 high address read zero", d, 32'h0);

    // R1 back-to-back commands
    @(negedge clk); cmdValid = 1; cmdWrite = 0; cmdAddr = 8'h04;
    @(negedge clk); check("R1 first back-to-back rsp", 32'(rspValid), 1);
    @(negedge clk); check("R1 second back-to-back rsp", 32'(rspValid), 1);
    cmdValid = 0;
    @(negedge clk); check("R1 rsp drops after last cmd", 32'(rspValid), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule